// File: doc/BRIEF.md
# Scaled Radix-2 FFT Butterfly

This block is the arithmetic core of a fixed-point FFT datapath. Each cycle it can accept one complex operand pair A and B, together with a complex twiddle W. All parts are 16-bit signed Q15 numbers. It forms the rotated term T = W·B, rounded to Q15. It returns the pair X = (A + T)/2 and Y = (A − T)/2. The halving is an arithmetic right shift by one bit, applied to both outputs and to the real and imaginary parts alike, at every pass.

Because every pass halves its results, a transform that stays in range at its input stays in range through every pass. The price is a fixed overall gain of 1/N: seven passes of a 128-point transform give 1/128. This uniform scale leaves the shape of the spectrum unchanged.

A 3-bit pass index travels with each operand pair. A running shift total comes out alongside the result, so the controller always knows the accumulated scale of the data it writes back. Twiddle generation, addressing, storage and reordering stay with the surrounding controller.

Top module: `fft_bfly_scaled`

## Requirements
- R1: All data ports carry 16-bit two's complement Q15 values (value = integer / 32768). The real part and the imaginary part have separate ports.
- R2: The rotated term is T_re = floor((B_re·W_re − B_im·W_im + 16384) / 32768) and T_im = floor((B_re·W_im + B_im·W_re + 16384) / 32768). This is round-half-up to Q15, computed without intermediate wrap.
- R3: The sum output is X = floor((A + T) / 2) per component. It never wraps when each component of A is in [−32768, 32767] and each component of T is in [−32768, 32768].
- R4: The difference output is Y = floor((A − T) / 2) per component, under the same no-wrap condition as R3.
- R5: The real and imaginary components are halved in exactly the same way, so X + Y equals A or A − 1 in each component.
- R6: out_valid_o is in_valid_i delayed by exactly 3 clock cycles. The block accepts one operand set per cycle with no stall, and data beats follow their valid.
- R7: stage_o equals the stage_i value captured with the same operand set. shift_total_o equals stage_o + 1 (a 4-bit value, 1 to 8).
- R8: While rst_ni is low, out_valid_o is 0. After reset is released, it stays 0 until a valid input has had 3 cycles to reach the output.
- R9: The −1.0 × −1.0 case (B = −32768, W = −32768, imaginary parts 0) yields T_re = +32768 without wrap. For example, A_re = 32767 gives X_re = 32767 and Y_re = −1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operand set valid this cycle |
| a_re_i | input | 16 | Operand A, real part |
| a_im_i | input | 16 | Operand A, imaginary part |
| b_re_i | input | 16 | Operand B, real part |
| b_im_i | input | 16 | Operand B, imaginary part |
| w_re_i | input | 16 | Twiddle, real part |
| w_im_i | input | 16 | Twiddle, imaginary part |
| stage_i | input | 3 | Pass index of this operand set |
| out_valid_o | output | 1 | Result pair valid |
| x_re_o | output | 16 | (A + T)/2, real part |
| x_im_o | output | 16 | (A + T)/2, imaginary part |
| y_re_o | output | 16 | (A − T)/2, real part |
| y_im_o | output | 16 | (A − T)/2, imaginary part |
| stage_o | output | 3 | Pass index carried with the result |
| shift_total_o | output | 4 | Right shifts applied up to and including this pass |

## Verification
Each error source shows up at the outputs three cycles after the operand set that exposes it. A wrong rounding constant or a dropped cross term moves X and Y by one or more LSBs. A missing sign extension or a logical shift in place of an arithmetic shift makes negative results wrap, and the −1.0 × −1.0 and full-scale negative corners expose this at once. A pipeline stage too many or too few misaligns out_valid_o, stage_o and the data by one cycle, so the very next beat after a gap in valid shows it.

// File: rtl/fft_bfly_pkg.sv
package fft_bfly_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned STAGE_W = 3;
  localparam int unsigned LATENCY = 3;
endpackage

// File: rtl/fft_bfly_cmul.sv
// Two-stage complex multiply: T = W*B rounded half-up to Q15.
module fft_bfly_cmul #(
  parameter int unsigned DW = 16,
  parameter int unsigned SW = 3,
  localparam int unsigned FRAC = DW - 1,
  localparam int unsigned PW   = 2 * DW,
  localparam int unsigned TW   = PW + 1 - FRAC
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 v_i,
  input  logic signed [DW-1:0] a_re_i,
  input  logic signed [DW-1:0] a_im_i,
  input  logic signed [DW-1:0] b_re_i,
  input  logic signed [DW-1:0] b_im_i,
  input  logic signed [DW-1:0] w_re_i,
  input  logic signed [DW-1:0] w_im_i,
  input  logic [SW-1:0]        stg_i,
  output logic                 v_o,
  output logic signed [DW-1:0] a_re_o,
  output logic signed [DW-1:0] a_im_o,
  output logic signed [TW-1:0] t_re_o,
  output logic signed [TW-1:0] t_im_o,
  output logic [SW-1:0]        stg_o
);
  localparam logic signed [PW:0] RND = {{(PW+1-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};

  // product index: 0 = br*wr, 1 = bi*wi, 2 = br*wi, 3 = bi*wr
  logic signed [DW-1:0] op_x [4];
  logic signed [DW-1:0] op_y [4];
  logic signed [PW-1:0] prod_q [4];

  assign op_x[0] = b_re_i;  assign op_y[0] = w_re_i;
  assign op_x[1] = b_im_i;  assign op_y[1] = w_im_i;
  assign op_x[2] = b_re_i;  assign op_y[2] = w_im_i;
  assign op_x[3] = b_im_i;  assign op_y[3] = w_re_i;

  for (genvar g = 0; g < 4; g++) begin : g_mul
    always_ff @(posedge clk_i) prod_q[g] <= op_x[g] * op_y[g];
  end

  logic                 v1_q;
  logic signed [DW-1:0] a1_re_q, a1_im_q;
  logic [SW-1:0]        stg1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v1_q <= 1'b0;
    else         v1_q <= v_i;
  end

  always_ff @(posedge clk_i) begin
    a1_re_q <= a_re_i;
    a1_im_q <= a_im_i;
    stg1_q  <= stg_i;
  end

  logic signed [PW:0] sum_re, sum_im, rnd_re, rnd_im;

  always_comb begin
    sum_re = {prod_q[0][PW-1], prod_q[0]} - {prod_q[1][PW-1], prod_q[1]};
    sum_im = {prod_q[2][PW-1], prod_q[2]} + {prod_q[3][PW-1], prod_q[3]};
    rnd_re = sum_re + RND;
    rnd_im = sum_im + RND;
  end

  logic v2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v2_q <= 1'b0;
    else         v2_q <= v1_q;
  end

  always_ff @(posedge clk_i) begin
    t_re_o <= rnd_re[PW:FRAC];
    t_im_o <= rnd_im[PW:FRAC];
    a_re_o <= a1_re_q;
    a_im_o <= a1_im_q;
    stg_o  <= stg1_q;
  end

  assign v_o = v2_q;

  // R6: valid moves one register per cycle through the multiplier
  assert_mul_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_i |=> v1_q);
  assert_rnd_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v1_q |=> v_o);
  // R2: rounding offset never lowers the value, and raises it by less than one LSB
  assert_round_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v1_q |-> (rnd_re >= sum_re) && (rnd_im >= sum_im));
endmodule

// File: rtl/fft_bfly_addsub.sv
// Final stage: sum/difference at widened precision, halved by arithmetic shift.
module fft_bfly_addsub #(
  parameter int unsigned DW = 16,
  parameter int unsigned TW = 18
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 v_i,
  input  logic signed [DW-1:0] a_re_i,
  input  logic signed [DW-1:0] a_im_i,
  input  logic signed [TW-1:0] t_re_i,
  input  logic signed [TW-1:0] t_im_i,
  output logic                 v_o,
  output logic signed [DW-1:0] x_re_o,
  output logic signed [DW-1:0] x_im_o,
  output logic signed [DW-1:0] y_re_o,
  output logic signed [DW-1:0] y_im_o
);
  localparam int unsigned SUMW = TW + 1;

  // lane 0 = real, lane 1 = imaginary; both use identical logic (R5)
  logic signed [DW-1:0] a_l [2];
  logic signed [TW-1:0] t_l [2];
  logic signed [DW-1:0] x_q [2];
  logic signed [DW-1:0] y_q [2];

  assign a_l[0] = a_re_i;  assign t_l[0] = t_re_i;
  assign a_l[1] = a_im_i;  assign t_l[1] = t_im_i;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic signed [SUMW-1:0] a_ext, t_ext, s_w, d_w;
    logic signed [TW-1:0]   s_half, d_half;

    always_comb begin
      a_ext  = {{(SUMW-DW){a_l[g][DW-1]}}, a_l[g]};
      t_ext  = {t_l[g][TW-1], t_l[g]};
      s_w    = a_ext + t_ext;
      d_w    = a_ext - t_ext;
      s_half = s_w[SUMW-1:1];
      d_half = d_w[SUMW-1:1];
    end

    always_ff @(posedge clk_i) begin
      x_q[g] <= s_half[DW-1:0];
      y_q[g] <= d_half[DW-1:0];
    end

    // R3, R4: halved result fits the output word for in-range operands
    assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_i |-> (s_half[TW-1:DW-1] == '0) || (s_half[TW-1:DW-1] == '1));
    assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_i |-> (d_half[TW-1:DW-1] == '0) || (d_half[TW-1:DW-1] == '1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_o <= 1'b0;
    else         v_o <= v_i;
  end

  assign x_re_o = x_q[0];
  assign x_im_o = x_q[1];
  assign y_re_o = y_q[0];
  assign y_im_o = y_q[1];
endmodule

// File: rtl/fft_bfly_scaled.sv
module fft_bfly_scaled
  import fft_bfly_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned SW = STAGE_W,
  localparam int unsigned TW = DW + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic signed [DW-1:0] a_re_i,
  input  logic signed [DW-1:0] a_im_i,
  input  logic signed [DW-1:0] b_re_i,
  input  logic signed [DW-1:0] b_im_i,
  input  logic signed [DW-1:0] w_re_i,
  input  logic signed [DW-1:0] w_im_i,
  input  logic [SW-1:0]        stage_i,
  output logic                 out_valid_o,
  output logic signed [DW-1:0] x_re_o,
  output logic signed [DW-1:0] x_im_o,
  output logic signed [DW-1:0] y_re_o,
  output logic signed [DW-1:0] y_im_o,
  output logic [SW-1:0]        stage_o,
  output logic [SW:0]          shift_total_o
);
  logic                 m_v;
  logic signed [DW-1:0] m_a_re, m_a_im;
  logic signed [TW-1:0] m_t_re, m_t_im;
  logic [SW-1:0]        m_stg;

  fft_bfly_cmul #(.DW(DW), .SW(SW)) u_cmul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .v_i    (in_valid_i),
    .a_re_i (a_re_i),
    .a_im_i (a_im_i),
    .b_re_i (b_re_i),
    .b_im_i (b_im_i),
    .w_re_i (w_re_i),
    .w_im_i (w_im_i),
    .stg_i  (stage_i),
    .v_o    (m_v),
    .a_re_o (m_a_re),
    .a_im_o (m_a_im),
    .t_re_o (m_t_re),
    .t_im_o (m_t_im),
    .stg_o  (m_stg)
  );

  fft_bfly_addsub #(.DW(DW), .TW(TW)) u_addsub (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .v_i    (m_v),
    .a_re_i (m_a_re),
    .a_im_i (m_a_im),
    .t_re_i (m_t_re),
    .t_im_i (m_t_im),
    .v_o    (out_valid_o),
    .x_re_o (x_re_o),
    .x_im_o (x_im_o),
    .y_re_o (y_re_o),
    .y_im_o (y_im_o)
  );

  logic [SW-1:0] stg_q;
  always_ff @(posedge clk_i) stg_q <= m_stg;

  assign stage_o       = stg_q;
  assign shift_total_o = {1'b0, stg_q} + 1'b1;

  // R6: fixed latency, both directions
  assert_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> ##3 out_valid_o);
  assert_no_spurious_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |-> ##3 !out_valid_o);
  // R7: pass index stays aligned with its data
  assert_stage_align_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> stage_o == $past(stage_i, 3));
  // R5: X + Y recovers A (or A-1) in both components
  assert_halve_re_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |->
      (({x_re_o[DW-1], x_re_o} + {y_re_o[DW-1], y_re_o} - $past({a_re_i[DW-1], a_re_i}, 3)) == '0) ||
      (({x_re_o[DW-1], x_re_o} + {y_re_o[DW-1], y_re_o} - $past({a_re_i[DW-1], a_re_i}, 3)) == '1));
  assert_halve_im_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |->
      (({x_im_o[DW-1], x_im_o} + {y_im_o[DW-1], y_im_o} - $past({a_im_i[DW-1], a_im_i}, 3)) == '0) ||
      (({x_im_o[DW-1], x_im_o} + {y_im_o[DW-1], y_im_o} - $past({a_im_i[DW-1], a_im_i}, 3)) == '1));
endmodule

// File: tb/fft_bfly_scaled_tb.sv
`timescale 1ns/1ps
module fft_bfly_scaled_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic               in_valid;
  logic signed [15:0] a_re, a_im, b_re, b_im, w_re, w_im;
  logic [2:0]         stage;
  logic               out_valid;
  logic signed [15:0] x_re, x_im, y_re, y_im;
  logic [2:0]         stage_o;
  logic [3:0]         shift_total;

  fft_bfly_scaled u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid),
    .a_re_i(a_re), .a_im_i(a_im), .b_re_i(b_re), .b_im_i(b_im),
    .w_re_i(w_re), .w_im_i(w_im), .stage_i(stage),
    .out_valid_o(out_valid), .x_re_o(x_re), .x_im_o(x_im),
    .y_re_o(y_re), .y_im_o(y_im), .stage_o(stage_o), .shift_total_o(shift_total)
  );

  typedef struct {
    bit v;
    int xr, xi, yr, yi, stg;
    string tag;
  } exp_t;

  exp_t hist [3];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference: R2 round-half-up product, R3/R4 floor halving
  function automatic int rot(int p, int q, int r, int s, bit sub);
    longint acc;
    acc = sub ? (longint'(p) * q - longint'(r) * s) : (longint'(p) * q + longint'(r) * s);
    acc = (acc + 64'sd16384) >>> 15;
    return int'(acc);
  endfunction

  function automatic int rnd_rng(int lim);
    return int'($urandom_range(2 * lim)) - lim;
  endfunction

  task automatic clear_hist();
    for (int i = 0; i < 3; i++) begin
      hist[i].v = 0; hist[i].xr = 0; hist[i].xi = 0; hist[i].yr = 0; hist[i].yi = 0;
      hist[i].stg = 0; hist[i].tag = "";
    end
  endtask

  // Called at negedge: check outputs of the set driven 3 negedges ago, then drive a new one
  task automatic step(bit v, int ar, int ai, int br, int bi, int wr, int wi, int st, string tag);
    int tr, ti;
    chk("R6 out_valid", int'(out_valid), int'(hist[2].v));
    if (hist[2].v) begin
      chk({"R3 x_re ", hist[2].tag}, int'(x_re), hist[2].xr);
      chk({"R4 y_re ", hist[2].tag}, int'(y_re), hist[2].yr);
      chk({"R5 x_im ", hist[2].tag}, int'(x_im), hist[2].xi);
      chk({"R5 y_im ", hist[2].tag}, int'(y_im), hist[2].yi);
      chk("R7 stage_o", int'(stage_o), hist[2].stg);
      chk("R7 shift_total", int'(shift_total), hist[2].stg + 1);
    end
    hist[2] = hist[1];
    hist[1] = hist[0];
    tr = rot(br, wr, bi, wi, 1'b1);
    ti = rot(br, wi, bi, wr, 1'b0);
    hist[0].v   = v;
    hist[0].xr  = (ar + tr) >>> 1;
    hist[0].xi  = (ai + ti) >>> 1;
    hist[0].yr  = (ar - tr) >>> 1;
    hist[0].yi  = (ai - ti) >>> 1;
    hist[0].stg = st;
    hist[0].tag = tag;
    in_valid = v;
    a_re = 16'(ar); a_im = 16'(ai);
    b_re = 16'(br); b_im = 16'(bi);
    w_re = 16'(wr); w_im = 16'(wi);
    stage = 3'(st);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    in_valid = 0; a_re = 0; a_im = 0; b_re = 0; b_im = 0; w_re = 0; w_im = 0; stage = 0;
    clear_hist();
    repeat (3) @(negedge clk);
    chk("R8 out_valid in reset", int'(out_valid), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R8 out_valid after reset", int'(out_valid), 0);

    // R9: -1.0 x -1.0 gives T = +1.0 without wrap
    step(1, 32767, 0, -32768, 0, -32768, 0, 0, "R9 minus-one squared A=+max");
    step(1, -32768, 0, -32768, 0, -32768, 0, 1, "R9 minus-one squared A=-1");
    step(1, 0, 0, 0, -32768, 0, -32768, 2, "R9 imag minus-one squared");
    // R1 full-scale negative components with near-unity twiddle
    step(1, -32768, -32768, -32768, -32768, 32767, 0, 3, "R1 full negative");
    step(1, 32767, 32767, 32767, 32767, 32767, 0, 7, "R1 full positive stage 7");
    // R2 rounding tie and just-below-tie
    step(1, 0, 0, 1, 0, 16384, 0, 4, "R2 round tie");
    step(1, 0, 0, -1, 0, 16384, 0, 5, "R2 negative tie");
    step(1, 0, 0, 3, 5, -7, 9, 6, "R2 small cross terms");
    // R3/R4 odd sums to check floor on negatives
    step(1, -3, 3, 0, 0, 0, 0, 0, "R3 odd floor");
    step(0, 0, 0, 0, 0, 0, 0, 0, "gap");
    step(1, 5, -5, 0, 0, 0, 0, 1, "R4 odd floor after gap");

    // Constrained random: |A|,|B| < 1, |W| <= 1; valid toggles
    for (int n = 0; n < 3000; n++) begin
      bit v;
      v = ($urandom_range(3) != 0);
      step(v, rnd_rng(23000), rnd_rng(23000), rnd_rng(23000), rnd_rng(23000),
           rnd_rng(23170), rnd_rng(23170), int'($urandom_range(7)), "R2 random");
    end

    // R8: mid-stream reset drops out_valid at once and keeps it low afterwards
    step(1, 100, 200, 300, 400, 500, 600, 2, "pre-reset");
    step(1, 100, 200, 300, 400, 500, 600, 2, "pre-reset");
    in_valid = 0;
    rst_ni = 1'b0;
    #1;
    chk("R8 out_valid during mid-run reset", int'(out_valid), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    clear_hist();
    for (int n = 0; n < 4; n++) step(0, 0, 0, 0, 0, 0, 0, 0, "R8 idle after reset");
    step(1, 1000, -1000, 2000, -2000, 16384, -16384, 3, "R6 first after reset");
    for (int n = 0; n < 4; n++) step(0, 0, 0, 0, 0, 0, 0, 0, "drain");
    finish_run();
  end
endmodule